// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a single memory-mapped timer. Software writes a start value, and the counter then steps down by one on every prescaled tick for as long as the timer is enabled. A control byte picks the tick rate (every clock, every 16th clock or every 256th clock), a 16-bit or 32-bit counter, and what happens when the count is at zero. In free-running mode the count wraps to full scale. In periodic mode it reloads from the load register. In one-shot mode it stays at zero.

The block is reached over a plain synchronous register port. Writes take effect at the clock edge where the write enable is sampled. Reads are combinational from the address. The tick that takes the count from one to zero latches a raw event flag. That flag, gated by an interrupt-enable bit, drives a level interrupt line, and software clears it by writing a dedicated address.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous active-low reset, the load, count, control and raw-status registers all read zero and `irq` is low.
- R2: A write to byte address 0x00 stores all 32 bits in the load register, which reads back at 0x00, and at the same edge sets the count, readable at 0x04, to that value. A load write wins over a same-cycle tick. Writes to 0x04 are ignored.
- R3: While control bit 7 (enable) is set, the count drops by one on each prescaled tick. While the bit is clear, the count holds.
- R4: Control bits 3:2 select the tick period: 00 gives one tick per clock, 01 one per 16 clocks, 10 one per 256 clocks, and 11 behaves like 10.
- R5: While the timer is disabled, the prescaler is held cleared. After the write that sets the enable bit, the first tick therefore moves the count exactly one full period later, and a partial period from before a disable is lost.
- R6: In free-running mode (control bit 6 and bit 0 clear), a tick at count zero loads full scale: 0xFFFF with control bit 1 clear, 0xFFFFFFFF with it set. The count therefore repeats with a modulus of full scale plus one.
- R7: In periodic mode (control bit 6 set, bit 0 clear), a tick at count zero reloads the load value, masked to the active width.
- R8: In one-shot mode (control bit 0 set, which takes priority over bit 6), the count stays at zero on later ticks until the load register is written. Counting then resumes from the new value.
- R9: With control bit 1 clear, only the low 16 bits of the load value are used, and reads of the count return zero in bits 31:16.
- R10: The tick that takes the count from 1 to 0 sets raw status bit 0, read at 0x10. Any write to 0x0C clears it, but a same-cycle set wins over the clear.
- R11: `irq` equals raw status AND control bit 5.
- R12: The control register at 0x08 is 8 bits wide and reads back as written, with zeros above. Reads of 0x0C, of unmapped word addresses, and of any address with a nonzero bit 1:0 return zero. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 5 | Byte address of the access |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Level interrupt: raw status gated by interrupt enable |

## Verification
The hardest conditions to reach from the ports depend on edge-exact alignment: a clear write landing on the very tick that reaches zero, and a re-enable that must discard a partly counted prescale period. The stimulus starts from a known load and enable edge and counts clocks, so it can place the clear write exactly on the zero-reaching edge. It also sets up the enable, disable and re-enable sequence so that the first tick's position reveals whether the prescaler restarted. The full 16-bit wrap needs 65,536 ticks at divide-by-one, so it is run once in full. The mode and prescale combinations are swept with a small load value, against counts computed as closed-form modular arithmetic.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the down-counting timer.
// Assumes word-aligned register offsets; the word indices below are
// compared against address bits [ADDR_W-1:2].
package tmr_pkg;

    localparam int unsigned WIDX_LOAD  = 0;
    localparam int unsigned WIDX_COUNT = 1;
    localparam int unsigned WIDX_CTRL  = 2;
    localparam int unsigned WIDX_CLEAR = 3;
    localparam int unsigned WIDX_RAW   = 4;

    // Control byte; the bit order is the software-visible layout.
    typedef struct packed {
        logic       run;      // bit 7: enable
        logic       reload;   // bit 6: periodic when set
        logic       irq_en;   // bit 5: interrupt enable
        logic       spare;    // bit 4: stored, no function
        logic [1:0] psel;     // bits 3:2: prescale select
        logic       wide;     // bit 1: 32-bit counter when set
        logic       single;   // bit 0: one-shot
    } ctrl_t;

    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_RELOAD = 2'd1,
        MODE_SINGLE = 2'd2
    } mode_e;

    // One-shot takes priority over periodic reload.
    function automatic mode_e mode_of(input ctrl_t c);
        if (c.single)      return MODE_SINGLE;
        else if (c.reload) return MODE_RELOAD;
        else               return MODE_FREE;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
// Prescaler: produces a one-cycle tick every 1, 2**MID_LOG2 or 2**HI_LOG2
// clocks while running. Assumes HI_LOG2 > MID_LOG2. The divider count is
// held cleared while not running, so each enable starts a fresh period.
module tmr_prescale #(
    parameter int unsigned MID_LOG2 = 4,
    parameter int unsigned HI_LOG2  = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] psel,
    output logic       tick
);
    localparam int unsigned PW = HI_LOG2;
    localparam logic [PW-1:0] LIM_MID = PW'((1 << MID_LOG2) - 1);

    logic [PW-1:0] pcnt;
    logic [PW-1:0] plimit;

    // Terminal count for the selected divisor (code 11 aliases code 10).
    always_comb begin
        case (psel)
            2'b00:   plimit = '0;
            2'b01:   plimit = LIM_MID;
            default: plimit = '1;
        endcase
    end

    // ">=" keeps the divider sane if the divisor is lowered mid-period.
    assign tick = run && (pcnt >= plimit);

    // Divider count: cleared when idle or on a tick, else advances.
    always_ff @(posedge clk) begin
        if (!rst_n)          pcnt <= '0;
        else if (!run || tick) pcnt <= '0;
        else                 pcnt <= pcnt + 1'b1;
    end

    AST_PRESCALE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> pcnt == '0); // R5
    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick && psel != 2'b00 |=> !tick || psel == 2'b00); // R4

endmodule

// File: rtl/tmr_counter.sv
`timescale 1ns/1ps
// Down counter with width masking and the three end-of-count rules.
// Assumes a load write and a control change never arrive in the same
// cycle (single register port). The stored value keeps all DATA_W bits;
// the active width is applied by mask on every use.
module tmr_counter import tmr_pkg::*; #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [DATA_W-1:0] ld_val,
    input  logic [DATA_W-1:0] load_q,
    input  logic              tick,
    input  logic              wide,
    input  mode_e             mode,
    output logic [DATA_W-1:0] count_view,
    output logic              zero_evt
);
    logic [DATA_W-1:0] cnt;
    logic [DATA_W-1:0] nxt;
    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] cur;

    // Active-width mask; a single-width build has no narrow variant.
    generate
        if (NARROW_W < DATA_W) begin : g_dual
            assign mask = wide ? {DATA_W{1'b1}}
                               : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
        end else begin : g_single
            assign mask = {DATA_W{1'b1}};
        end
    endgenerate

    assign cur        = cnt & mask;
    assign count_view = cur;

    // Next count: load write first, then tick handling per mode.
    always_comb begin
        nxt      = cnt;
        zero_evt = 1'b0;
        if (ld_we) begin
            nxt = ld_val & mask;
        end else if (tick) begin
            if (cur == '0) begin
                case (mode)
                    MODE_RELOAD: nxt = load_q & mask;
                    MODE_FREE:   nxt = mask;
                    default:     nxt = cnt;
                endcase
            end else begin
                nxt      = cur - DATA_W'(1);
                zero_evt = (cur == DATA_W'(1));
            end
        end
    end

    // Count register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= nxt;
    end

    AST_LOAD_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |=> count_view == ($past(ld_val) & $past(mask))); // R2
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick && !ld_we |=> $stable(cnt)); // R3
    AST_FREE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !ld_we && mode == MODE_FREE && cur == '0 |=> cnt == $past(mask)); // R6
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !ld_we && mode == MODE_RELOAD && cur == '0
        |=> cnt == ($past(load_q) & $past(mask))); // R7
    AST_SINGLE_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
        tick && !ld_we && mode == MODE_SINGLE && cur == '0 |=> $stable(cnt)); // R8

endmodule

// File: rtl/tmr_regs.sv
`timescale 1ns/1ps
// Register file and address decode: load, control and raw-status
// registers, the clear strobe and the combinational read mux.
// Assumes ADDR_W >= 5; accesses with nonzero address bits 1:0 hit nothing.
module tmr_regs import tmr_pkg::*; #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] count_view,
    input  logic              zero_evt,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] load_q,
    output logic              ld_we,
    output ctrl_t             ctrl,
    output logic              irq
);
    localparam int unsigned IDX_W  = ADDR_W - 2;
    localparam int unsigned CTRL_W = $bits(ctrl_t);

    logic             aligned;
    logic [IDX_W-1:0] idx;
    logic             sel_load, sel_count, sel_ctrl, sel_clear, sel_raw;
    logic             ctl_we, clr_we;
    logic             raw;

    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign idx       = bus_addr[ADDR_W-1:2];
    assign sel_load  = aligned && idx == IDX_W'(WIDX_LOAD);
    assign sel_count = aligned && idx == IDX_W'(WIDX_COUNT);
    assign sel_ctrl  = aligned && idx == IDX_W'(WIDX_CTRL);
    assign sel_clear = aligned && idx == IDX_W'(WIDX_CLEAR);
    assign sel_raw   = aligned && idx == IDX_W'(WIDX_RAW);

    assign ld_we  = bus_we && sel_load;
    assign ctl_we = bus_we && sel_ctrl;
    assign clr_we = bus_we && sel_clear;

    // Load register keeps the full written word.
    always_ff @(posedge clk) begin
        if (!rst_n)     load_q <= '0;
        else if (ld_we) load_q <= bus_wdata;
    end

    // Control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl <= '0;
        else if (ctl_we) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    // Raw event flag: a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        raw <= 1'b0;
        else if (zero_evt) raw <= 1'b1;
        else if (clr_we)   raw <= 1'b0;
    end

    assign irq = raw & ctrl.irq_en;

    // Read mux; anything unmapped reads zero.
    always_comb begin
        bus_rdata = '0;
        if (sel_load)       bus_rdata = load_q;
        else if (sel_count) bus_rdata = count_view;
        else if (sel_ctrl)  bus_rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl};
        else if (sel_raw)   bus_rdata = {{(DATA_W-1){1'b0}}, raw};
    end

    AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> raw); // R10
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we && !zero_evt |=> !raw); // R10
    AST_CTRL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(ctrl)); // R12
    AST_LOAD_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_we |=> $stable(load_q)); // R2

endmodule

// File: rtl/tick_timer.sv
`timescale 1ns/1ps
// Top of the prescaled down-counting timer: register file, prescaler and
// counter. Assumes one synchronous clock domain and a single access per
// cycle on the register port.
module tick_timer import tmr_pkg::*; #(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NARROW_W = 16,
    parameter int unsigned ADDR_W   = 5,
    parameter int unsigned MID_LOG2 = 4,
    parameter int unsigned HI_LOG2  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    logic [DATA_W-1:0] count_view;
    logic [DATA_W-1:0] load_q;
    logic              zero_evt;
    logic              ld_we;
    logic              tick;
    ctrl_t             ctrl;
    mode_e             mode;

    assign mode = mode_of(ctrl);

    tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .count_view(count_view), .zero_evt(zero_evt),
        .bus_rdata(bus_rdata), .load_q(load_q), .ld_we(ld_we),
        .ctrl(ctrl), .irq(irq)
    );

    tmr_prescale #(.MID_LOG2(MID_LOG2), .HI_LOG2(HI_LOG2)) u_pre (
        .clk(clk), .rst_n(rst_n),
        .run(ctrl.run), .psel(ctrl.psel), .tick(tick)
    );

    tmr_counter #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .ld_we(ld_we), .ld_val(bus_wdata), .load_q(load_q),
        .tick(tick), .wide(ctrl.wide), .mode(mode),
        .count_view(count_view), .zero_evt(zero_evt)
    );

endmodule

// File: tb/tick_timer_tb.sv
`timescale 1ns/1ps
module tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    tick_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; the write lands on the next rising edge.
    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] model(input int mode, input longint ld,
                                          input longint t, input longint fs);
        longint m;
        if (mode == 0) begin
            m = (ld - t) % (fs + 1);
            if (m < 0) m += fs + 1;
            return m[31:0];
        end else if (mode == 1) begin
            m = ld - (t % (ld + 1));
            return m[31:0];
        end else begin
            m = (t >= ld) ? 0 : ld - t;
            return m[31:0];
        end
    endfunction

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        rd(5'h00, v); chk("R1 load", v, 32'h0);
        rd(5'h04, v); chk("R1 count", v, 32'h0);
        rd(5'h08, v); chk("R1 ctrl", v, 32'h0);
        rd(5'h10, v); chk("R1 raw", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2: wide load, immediate count, readback; count writes ignored
        wr(5'h08, 32'h02);
        wr(5'h00, 32'h89ABCDEF);
        rd(5'h04, v); chk("R2 count after load", v, 32'h89ABCDEF);
        rd(5'h00, v); chk("R2 load readback", v, 32'h89ABCDEF);
        wr(5'h04, 32'h00001234);
        rd(5'h04, v); chk("R2 count write ignored", v, 32'h89ABCDEF);

        // R9: narrow mode masks the count, load keeps all bits
        wr(5'h08, 32'h00);
        wr(5'h00, 32'h12345678);
        rd(5'h04, v); chk("R9 narrow count", v, 32'h00005678);
        rd(5'h00, v); chk("R9 load full", v, 32'h12345678);

        // R3: disabled timer holds
        step(20);
        rd(5'h04, v); chk("R3 hold disabled", v, 32'h00005678);

        // R12: control readback and unmapped reads
        wr(5'h08, 32'h1E);
        rd(5'h08, v); chk("R12 ctrl readback", v, 32'h1E);
        wr(5'h08, 32'h00);
        rd(5'h14, v); chk("R12 unmapped", v, 32'h0);
        rd(5'h01, v); chk("R12 misaligned", v, 32'h0);
        rd(5'h0C, v); chk("R12 clear reads zero", v, 32'h0);
        wr(5'h02, 32'hFFFFFFFF);
        rd(5'h00, v); chk("R12 misaligned write ignored", v, 32'h12345678);

        // Sweep: every prescale code x every mode, load 5, narrow width
        for (int ps = 0; ps < 4; ps++) begin
            for (int md = 0; md < 3; md++) begin
                int d, stp, n;
                logic [31:0] cw;
                logic ie;
                d   = (ps == 0) ? 1 : (ps == 1) ? 16 : 256;
                stp = (ps == 0) ? 1 : (ps == 1) ? 11 : 173;
                ie  = (md != 0);
                cw  = 32'h80 | (md == 1 ? 32'h40 : 32'h0) | (ie ? 32'h20 : 32'h0)
                    | (32'(ps) << 2) | (md == 2 ? 32'h1 : 32'h0);
                wr(5'h08, 32'h0);
                wr(5'h0C, 32'h0);
                wr(5'h00, 32'd5);
                wr(5'h08, cw);
                n = 0;
                for (int s = 0; s < 10; s++) begin
                    longint t;
                    logic [31:0] r;
                    step(stp);
                    n += stp;
                    t = n / d;
                    rd(5'h04, v);
                    chk(md == 0 ? "R4/R6 free sweep" : md == 1 ? "R4/R7 periodic sweep"
                                : "R4/R8 one-shot sweep", v, model(md, 5, t, 65535));
                    rd(5'h10, r);
                    chk("R10 raw sweep", r, (t >= 5) ? 32'h1 : 32'h0);
                    chk("R11 irq sweep", {31'b0, irq}, {31'b0, r[0] & ie});
                end
            end
        end

        // R7/R9: periodic reload uses only the low 16 load bits
        wr(5'h08, 32'h0);
        wr(5'h00, 32'hABCD0002);
        wr(5'h08, 32'hC0);
        step(3);
        rd(5'h04, v); chk("R7 narrow reload", v, 32'h2);

        // R6: full 16-bit wrap
        wr(5'h08, 32'h0);
        wr(5'h00, 32'd3);
        wr(5'h08, 32'h80);
        step(4);
        rd(5'h04, v); chk("R6 wrap to 0xFFFF", v, 32'h0000FFFF);
        step(65535);
        rd(5'h04, v); chk("R6 zero after full lap", v, 32'h0);
        step(1);
        rd(5'h04, v); chk("R6 second wrap", v, 32'h0000FFFF);

        // R6: 32-bit wrap
        wr(5'h08, 32'h0);
        wr(5'h00, 32'd2);
        wr(5'h08, 32'h82);
        step(3);
        rd(5'h04, v); chk("R6 wide wrap", v, 32'hFFFFFFFF);
        step(1);
        rd(5'h04, v); chk("R6 wide after wrap", v, 32'hFFFFFFFE);

        // R5: partial prescale period is discarded on re-enable
        wr(5'h08, 32'h0);
        wr(5'h00, 32'd100);
        wr(5'h08, 32'h84);
        step(5);
        wr(5'h08, 32'h04);
        wr(5'h08, 32'h84);
        step(15);
        rd(5'h04, v); chk("R5 no tick before full period", v, 32'd100);
        step(1);
        rd(5'h04, v); chk("R5 first tick after 16", v, 32'd99);

        // R8: one-shot parks at zero, load restarts it
        wr(5'h08, 32'h0);
        wr(5'h00, 32'd2);
        wr(5'h08, 32'hC1);
        step(10);
        rd(5'h04, v); chk("R8 parked at zero", v, 32'h0);
        wr(5'h00, 32'd4);
        rd(5'h04, v); chk("R8 load while parked", v, 32'd4);
        step(2);
        rd(5'h04, v); chk("R8 counting again", v, 32'd2);

        // R10: clear write on the zero-reaching edge loses to the event
        wr(5'h08, 32'h0);
        wr(5'h0C, 32'h0);
        rd(5'h10, v); chk("R10 cleared", v, 32'h0);
        wr(5'h00, 32'd3);
        wr(5'h08, 32'hC0);
        step(2);
        wr(5'h0C, 32'h0);
        rd(5'h04, v); chk("R10 count reached zero", v, 32'h0);
        rd(5'h10, v); chk("R10 set wins over clear", v, 32'h1);
        chk("R11 irq masked", {31'b0, irq}, 32'h0);
        wr(5'h08, 32'h20);
        chk("R11 irq enabled", {31'b0, irq}, 32'h1);
        wr(5'h0C, 32'h0);
        rd(5'h10, v); chk("R10 plain clear", v, 32'h0);
        chk("R11 irq after clear", {31'b0, irq}, 32'h0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1900000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule